// File: doc/BRIEF.md
# Serial NOR Flash Emulator

This block is a synthesizable SPI slave (mode 0, most significant bit first) that behaves like a small serial NOR flash device. Its purpose is to serve as a target for flash host controllers during verification or on a prototyping board. All of its logic runs on a system clock. The SPI chip select, clock and data-in lines are oversampled, so the SPI clock must stay well below a quarter of the system clock.

The emulator holds a byte array of `2**ADDR_W` entries, which comes out of reset erased (FFh). It also keeps a write-enable latch and a busy flag. Programming can only clear bits. Sector and bulk erase restore FFh. Each internal program or erase cycle lasts a parameterised number of system clocks, and it keeps running after chip select goes high. A deep power-down state locks out every instruction except the release instruction, which also returns a fixed signature byte.

Top module: `flashEmu`

## Requirements
- R1: Page program (02h, 3 address bytes, data) stores, for each byte, the old content ANDed with the received byte, so bits can only go from 1 to 0.
- R2: Sector erase (D8h, 3 address bytes) sets every byte of the `2**SECT_W`-byte sector holding the address to FFh and leaves other sectors unchanged. Bulk erase (C7h) sets the whole array to FFh.
- R3: Write enable (06h) sets the latch when chip select rises. Page program, sector erase and bulk erase received while the latch is clear are ignored, and memory and status stay unchanged.
- R4: Read status (05h) returns the status byte on every following byte. Bit 0 is busy (1 from the start of a program or erase cycle for at least the configured cycle count). Bit 1 is the write-enable latch. All other bits are 0.
- R5: The write-enable latch clears by itself when a program or erase cycle completes.
- R6: A program or erase starts only when chip select rises after a whole number of bytes. A partial last byte aborts the command, leaving memory, latch and busy bit unchanged.
- R7: Program data addresses wrap within the current 256-byte page, and when more than 256 data bytes arrive only the last 256 are kept.
- R8: While busy, every instruction other than read status is ignored, and a read returns 00h.
- R9: After deep power-down (B9h), every instruction except release is ignored (status and data reads return 00h, writes have no effect) until release is received.
- R10: Release (ABh) leaves deep power-down when chip select rises. After the opcode and 3 dummy bytes it returns the `SIG_BYTE` value.
- R11: Read data (03h, 3 address bytes) returns consecutive bytes from the address, wrapping from the last array byte to byte 0. The data-out line reads 0 whenever no data is being returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Chip select, active low |
| spiSck | input | 1 | SPI clock (mode 0) |
| spiMosi | input | 1 | Serial data into the emulator |
| spiMiso | output | 1 | Serial data out of the emulator |

## Verification
The bench builds the emulator with `ADDR_W=10`, `PAGE_W=8` and `SECT_W=9`. This gives four pages and two sectors, so a sector erase can be seen leaving the other sector intact, and a read can be carried across the end of the array. The cycle counts are cut to 300, 700 and 1500 clocks. With these values the busy bit can be sampled both inside and after a bulk erase, and a complete 258-byte page program, which overwrites the first two buffered bytes, fits in a short run.

// File: rtl/flashEmuPkg.sv
package flashEmuPkg;
  localparam logic [7:0] CMD_WEN   = 8'h06;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_SECT  = 8'hD8;
  localparam logic [7:0] CMD_BULK  = 8'hC7;
  localparam logic [7:0] CMD_STAT  = 8'h05;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_SLEEP = 8'hB9;
  localparam logic [7:0] CMD_WAKE  = 8'hAB;

  typedef enum logic [1:0] {TX_NONE, TX_STAT, TX_MEM, TX_SIG} txSel_e;
  typedef enum logic [1:0] {JOB_PROG, JOB_SECT, JOB_BULK} job_e;

  // strobes from the control to the datapath, one clock wide
  typedef struct packed {
    logic       outClr;
    logic       shift;
    logic       loadOut;
    txSel_e     txSel;
    logic       bufClr;
    logic       bufWr;
    logic [7:0] bufData;
    logic       startProg;
    logic       startSect;
    logic       startBulk;
  } stb_t;
endpackage

// File: rtl/flashEmuCtrl.sv
module flashEmuCtrl
  import flashEmuPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wip,
  input  logic              done,
  output stb_t              stb,
  output logic [ADDR_W-1:0] addr,
  output logic              wel,
  output logic              deep,
  output logic              csRise
);
  localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] AD_ONE = ADDR_W'(1);

  logic [1:0] csSy, sckSy, mosiSy;
  logic       csPrev, sckPrev;
  logic [2:0] bitCnt, byteCnt;
  logic [6:0] shIn;
  logic [7:0] opcode, rxByte;
  logic       opValid, pend, acceptNow, commit;
  logic       sel, sckRise, sckFall, byteDone;
  txSel_e     pendSel;

  assign sel      = ~csSy[1];
  assign sckRise  = sel & sckSy[1] & ~sckPrev;
  assign sckFall  = sel & ~sckSy[1] & sckPrev;
  assign csRise   = csSy[1] & ~csPrev;
  assign rxByte   = {shIn, mosiSy[1]};
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign commit   = csRise && opValid && (bitCnt == 3'd0);

  // decide at opcode time whether the instruction is honoured
  always_comb begin
    if (wip)       acceptNow = (rxByte == CMD_STAT);
    else if (deep) acceptNow = (rxByte == CMD_WAKE);
    else begin
      case (rxByte)
        CMD_PROG, CMD_SECT, CMD_BULK:                     acceptNow = wel;
        CMD_WEN, CMD_STAT, CMD_READ, CMD_SLEEP, CMD_WAKE: acceptNow = 1'b1;
        default:                                          acceptNow = 1'b0;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.outClr    = ~sel;
    stb.loadOut   = sckFall & pend;
    stb.shift     = sckFall & ~pend;
    stb.txSel     = pendSel;
    stb.bufData   = rxByte;
    stb.bufClr    = byteDone && (byteCnt == 3'd0) && acceptNow && (rxByte == CMD_PROG);
    stb.bufWr     = byteDone && (byteCnt >= 3'd4) && opValid && (opcode == CMD_PROG);
    stb.startProg = commit && (opcode == CMD_PROG) && (byteCnt >= 3'd5);
    stb.startSect = commit && (opcode == CMD_SECT) && (byteCnt == 3'd4);
    stb.startBulk = commit && (opcode == CMD_BULK) && (byteCnt == 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy    <= 2'b11;
      sckSy   <= '0;
      mosiSy  <= '0;
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      shIn    <= '0;
      opcode  <= '0;
      opValid <= 1'b0;
      pend    <= 1'b0;
      pendSel <= TX_NONE;
      addr    <= '0;
      wel     <= 1'b0;
      deep    <= 1'b0;
    end else begin
      csSy    <= {csSy[0], csN};
      sckSy   <= {sckSy[0], sck};
      mosiSy  <= {mosiSy[0], mosi};
      csPrev  <= csSy[1];
      sckPrev <= sckSy[1];
      if (!sel) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        opValid <= 1'b0;
        pend    <= 1'b0;
      end else if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        shIn   <= rxByte[6:0];
        if (byteDone) begin
          if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
          if (byteCnt == 3'd0) begin
            opcode  <= rxByte;
            opValid <= acceptNow;
            if (acceptNow && rxByte == CMD_STAT) begin
              pend    <= 1'b1;
              pendSel <= TX_STAT;
            end
          end else if (opValid) begin
            if (byteCnt <= 3'd3 && opcode inside {CMD_READ, CMD_PROG, CMD_SECT, CMD_BULK})
              addr <= ADDR_W'({addr, rxByte});
            case (opcode)
              CMD_STAT: begin pend <= 1'b1; pendSel <= TX_STAT; end
              CMD_READ: if (byteCnt >= 3'd3) begin pend <= 1'b1; pendSel <= TX_MEM; end
              CMD_WAKE: if (byteCnt >= 3'd3) begin pend <= 1'b1; pendSel <= TX_SIG; end
              CMD_PROG: if (byteCnt >= 3'd4) addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PG_ONE;
              default: ;
            endcase
          end
        end
      end else if (sckFall && pend) begin
        pend <= 1'b0;
        if (opcode == CMD_READ) addr <= addr + AD_ONE;
      end
      if (done) wel <= 1'b0;
      if (commit) begin
        case (opcode)
          CMD_WEN:   wel  <= 1'b1;
          CMD_SLEEP: deep <= 1'b1;
          CMD_WAKE:  deep <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flashEmuData.sv
module flashEmuData
  import flashEmuPkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter int         PAGE_W      = 8,
  parameter int         SECT_W      = 9,
  parameter int         PROG_CYCLES = 2000,
  parameter int         SECT_CYCLES = 20000,
  parameter int         BULK_CYCLES = 60000,
  parameter logic [7:0] SIG_BYTE    = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wel,
  output logic              wip,
  output logic              done,
  output logic              miso
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMAX  = (PROG_CYCLES > SECT_CYCLES)
                       ? ((PROG_CYCLES > BULK_CYCLES) ? PROG_CYCLES : BULK_CYCLES)
                       : ((SECT_CYCLES > BULK_CYCLES) ? SECT_CYCLES : BULK_CYCLES);
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_W) - 1);
  localparam logic [ADDR_W-1:0] AD_ONE    = ADDR_W'(1);
  localparam logic [TW-1:0] T_PROG = TW'(PROG_CYCLES - 1);
  localparam logic [TW-1:0] T_SECT = TW'(SECT_CYCLES - 1);
  localparam logic [TW-1:0] T_BULK = TW'(BULK_CYCLES - 1);

  logic [7:0]        mem   [DEPTH];
  logic [7:0]        pgBuf [PAGE];
  logic [PAGE-1:0]   pgVld;
  logic              busy, walkEnd, startAny;
  logic [ADDR_W-1:0] walk, base, wIdx, walkLast;
  logic [PAGE_W-1:0] pIdx;
  logic [TW-1:0]     cnt;
  logic [7:0]        outReg;
  job_e              job;

  assign wip      = busy;
  assign miso     = outReg[7];
  assign startAny = stb.startProg | stb.startSect | stb.startBulk;
  assign pIdx     = walk[PAGE_W-1:0];

  always_comb begin
    case (job)
      JOB_PROG: begin wIdx = (base & ~PAGE_MASK) | (walk & PAGE_MASK); walkLast = PAGE_MASK; end
      JOB_SECT: begin wIdx = (base & ~SECT_MASK) | (walk & SECT_MASK); walkLast = SECT_MASK; end
      default:  begin wIdx = walk;                                     walkLast = '1;        end
    endcase
  end

  // internal cycle: walk the target bytes, hold busy for at least the count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; walkEnd <= 1'b0; walk <= '0; base <= '0;
      cnt  <= '0;   job <= JOB_PROG;  done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (startAny && !busy) begin
        busy    <= 1'b1;
        walk    <= '0;
        walkEnd <= 1'b0;
        base    <= addr;
        job     <= stb.startProg ? JOB_PROG : (stb.startSect ? JOB_SECT : JOB_BULK);
        cnt     <= stb.startProg ? T_PROG : (stb.startSect ? T_SECT : T_BULK);
      end else if (busy) begin
        if (!walkEnd) begin
          walk <= walk + AD_ONE;
          if (walk == walkLast) walkEnd <= 1'b1;
        end
        if (cnt != '0) cnt <= cnt - TW'(1);
        else if (walkEnd) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (busy && !walkEnd) begin
      if (job == JOB_PROG) begin
        if (pgVld[pIdx]) mem[wIdx] <= mem[wIdx] & pgBuf[pIdx];
      end else begin
        mem[wIdx] <= 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) pgBuf[addr[PAGE_W-1:0]] <= stb.bufData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pgVld <= '0;
    else if (stb.bufClr) pgVld <= '0;
    else if (stb.bufWr)  pgVld[addr[PAGE_W-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outReg <= '0;
    else if (stb.outClr)  outReg <= '0;
    else if (stb.loadOut) begin
      case (stb.txSel)
        TX_STAT: outReg <= {6'b0, wel, busy};
        TX_MEM:  outReg <= mem[addr];
        TX_SIG:  outReg <= SIG_BYTE;
        default: outReg <= '0;
      endcase
    end else if (stb.shift) outReg <= {outReg[6:0], 1'b0};
  end
endmodule

// File: rtl/flashEmu.sv
module flashEmu
  import flashEmuPkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter int         PAGE_W      = 8,
  parameter int         SECT_W      = 9,
  parameter int         PROG_CYCLES = 2000,
  parameter int         SECT_CYCLES = 20000,
  parameter int         BULK_CYCLES = 60000,
  parameter logic [7:0] SIG_BYTE    = 8'h13
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiSck,
  input  logic spiMosi,
  output logic spiMiso
);
  stb_t              stb;
  logic [ADDR_W-1:0] addr;
  logic              wel, deep, csRise, wip, done;

  flashEmuCtrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .sck(spiSck), .mosi(spiMosi),
    .wip(wip), .done(done), .stb(stb), .addr(addr), .wel(wel),
    .deep(deep), .csRise(csRise)
  );

  flashEmuData #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
    .PROG_CYCLES(PROG_CYCLES), .SECT_CYCLES(SECT_CYCLES),
    .BULK_CYCLES(BULK_CYCLES), .SIG_BYTE(SIG_BYTE)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wel(wel),
    .wip(wip), .done(done), .miso(spiMiso)
  );
endmodule

// File: rtl/flashEmuChk.sv
module flashEmuChk (
  input logic clk,
  input logic rstN,
  input logic wip,
  input logic wel,
  input logic deep,
  input logic csRise,
  input logic startProg,
  input logic startSect,
  input logic startBulk
);
  logic anyStart;
  assign anyStart = startProg | startSect | startBulk;

  assert_single_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startProg, startSect, startBulk}));
  assert_start_at_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |-> csRise);
  assert_start_needs_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |-> wel);
  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |-> !wip);
  assert_start_awake_R9: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |-> !deep);
  assert_busy_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> wip);
  assert_latch_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |=> !wel);
endmodule

bind flashEmu flashEmuChk u_chk (
  .clk(clk), .rstN(rstN), .wip(wip), .wel(wel), .deep(deep), .csRise(csRise),
  .startProg(stb.startProg), .startSect(stb.startSect), .startBulk(stb.startBulk)
);

// File: tb/flashEmu_bench.sv
module flashEmu_bench;
  localparam int         HALF = 6;
  localparam int         T_PROG = 300;
  localparam int         T_SECT = 700;
  localparam int         T_BULK = 1500;
  localparam logic [7:0] SIG = 8'h5C;

  // {address[15:0], program data, expected read-back}
  localparam logic [31:0] VEC [4] = '{
    32'h0010_A5_A5, 32'h0010_3C_24, 32'h02FF_0F_0F, 32'h0100_80_80
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int   nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  flashEmu #(
    .ADDR_W(10), .PAGE_W(8), .SECT_W(9), .PROG_CYCLES(T_PROG),
    .SECT_CYCLES(T_SECT), .BULK_CYCLES(T_BULK), .SIG_BYTE(SIG)
  ) u_flashEmu (
    .clk(clk), .rstN(rstN), .spiCsN(csN), .spiSck(sck), .spiMosi(mosi), .spiMiso(miso)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      @(negedge clk); mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso; sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    sendBits(tx, 8, rx);
  endtask

  task automatic csDown();
    @(negedge clk); csN = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (4) @(negedge clk); csN = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic oneByteCmd(input logic [7:0] op);
    logic [7:0] d;
    csDown(); xfer(op, d); csUp();
  endtask

  task automatic getStatus(output logic [7:0] s);
    logic [7:0] d;
    csDown(); xfer(8'h05, d); xfer(8'h00, s); csUp();
  endtask

  task automatic sendAddr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    xfer(op, d); xfer(8'h00, d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic readTwo(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
    csDown(); sendAddr(8'h03, a); xfer(8'h00, d0); xfer(8'h00, d1); csUp();
  endtask

  task automatic readOne(input logic [15:0] a, output logic [7:0] d0);
    logic [7:0] d1;
    readTwo(a, d0, d1);
  endtask

  task automatic progOne(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    csDown(); sendAddr(8'h02, a); xfer(v, d); csUp();
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      getStatus(s);
      if (s[0] == 1'b0) return;
    end
    chk("R4 busy never cleared", 8'h01, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : stim
    logic [7:0] s, d0, d1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    getStatus(s);     chk("R4 status after reset", s, 8'h00);
    readOne(16'h0020, d0); chk("R11 erased after reset", d0, 8'hFF);

    // program without write enable (R3)
    progOne(16'h0020, 8'h00);
    getStatus(s);     chk("R3 no cycle without latch", s, 8'h00);
    readOne(16'h0020, d0); chk("R3 memory untouched", d0, 8'hFF);

    // vector table: program, busy status, latch clear, read-back
    for (int v = 0; v < 4; v++) begin
      oneByteCmd(8'h06);
      progOne(VEC[v][31:16], VEC[v][15:8]);
      getStatus(s); chk("R4 busy and latch during program", s, 8'h03);
      waitIdle();
      getStatus(s); chk("R5 latch cleared after program", s, 8'h00);
      readOne(VEC[v][31:16], d0); chk("R1 stored value is AND", d0, VEC[v][7:0]);
    end

    // page wrap (R7)
    oneByteCmd(8'h06);
    csDown(); sendAddr(8'h02, 16'h00FE);
    xfer(8'h11, d0); xfer(8'h22, d0); xfer(8'h33, d0); xfer(8'h44, d0);
    csUp(); waitIdle();
    readTwo(16'h00FE, d0, d1);
    chk("R7 byte at FE", d0, 8'h11); chk("R7 byte at FF", d1, 8'h22);
    readTwo(16'h0000, d0, d1);
    chk("R7 wrapped byte at 000", d0, 8'h33); chk("R7 wrapped byte at 001", d1, 8'h44);
    readTwo(16'h03FF, d0, d1);
    chk("R11 last array byte", d0, 8'hFF); chk("R11 read wraps to 000", d1, 8'h33);

    // more than 256 data bytes: only last 256 kept (R7)
    oneByteCmd(8'h06);
    csDown(); sendAddr(8'h02, 16'h0100);
    for (int k = 0; k < 258; k++) xfer((k < 256) ? 8'h00 : 8'hFF, d0);
    csUp(); waitIdle();
    readTwo(16'h0100, d0, d1);
    chk("R7 offset 0 overwritten by late byte", d0, 8'h80);
    chk("R7 offset 1 overwritten by late byte", d1, 8'hFF);
    readOne(16'h0102, d0); chk("R7 offset 2 from first pass", d0, 8'h00);

    // partial last byte aborts (R6)
    oneByteCmd(8'h06);
    csDown(); sendAddr(8'h02, 16'h0200); xfer(8'h00, d0); sendBits(8'h00, 5, d0); csUp();
    getStatus(s);     chk("R6 abort keeps latch, no busy", s, 8'h02);
    readOne(16'h0200, d0); chk("R6 abort leaves memory", d0, 8'hFF);

    // sector erase (R2)
    csDown(); sendAddr(8'hD8, 16'h0050); csUp();
    getStatus(s); chk("R4 busy during sector erase", s, 8'h03);
    waitIdle();
    readOne(16'h0010, d0); chk("R2 sector erased at 010", d0, 8'hFF);
    readOne(16'h0100, d0); chk("R2 sector erased at 100", d0, 8'hFF);
    readOne(16'h02FF, d0); chk("R2 other sector kept", d0, 8'h0F);

    // bulk erase, busy window, ignore while busy (R2 R4 R8)
    oneByteCmd(8'h06);
    oneByteCmd(8'hC7);
    getStatus(s);     chk("R4 busy at bulk start", s, 8'h03);
    readOne(16'h02FF, d0); chk("R8 read ignored while busy", d0, 8'h00);
    repeat (T_BULK / 4) @(negedge clk);
    getStatus(s);     chk("R4 still busy mid bulk", s, 8'h03);
    repeat (T_BULK) @(negedge clk);
    getStatus(s);     chk("R5 idle and latch clear after bulk", s, 8'h00);
    readOne(16'h02FF, d0); chk("R2 bulk erased whole array", d0, 8'hFF);
    readOne(16'h0000, d0); chk("R2 bulk erased byte 0", d0, 8'hFF);

    // deep power-down and release (R9 R10)
    oneByteCmd(8'h06);
    oneByteCmd(8'hB9);
    progOne(16'h0300, 8'h00);
    getStatus(s);     chk("R9 status ignored in power-down", s, 8'h00);
    readOne(16'h02FF, d0); chk("R9 read ignored in power-down", d0, 8'h00);
    csDown();
    xfer(8'hAB, d0); xfer(8'h00, d0); xfer(8'h00, d0); xfer(8'h00, d0); xfer(8'h00, d0);
    csUp();
    chk("R10 signature byte", d0, SIG);
    getStatus(s);     chk("R10 awake, latch kept, no cycle ran", s, 8'h02);
    readOne(16'h0300, d0); chk("R9 program ignored in power-down", d0, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule